// File: doc/BRIEF.md
# Chained Debug Trigger Hit Combiner

This block keeps ten hardware debug triggers and tests them every cycle against the instruction fetch PC, the load address and the store address that the pipeline presents, each qualified by its own valid bit. Triggers come in five fixed pairs. Each pair watches a fixed combination of event kinds. A pair can be chained, and then it reports a hit only when both of its members match together.

The combined outcome is registered. It is a fire flag, a flag that says whether the trap is taken before the current instruction or after it, and a ten-bit vector of the triggers that hit. Software, or a control unit, loads each trigger through a single write port that carries the whole trigger setting in one beat. Load data-value comparison, privilege filtering and the trap entry itself are handled elsewhere.

Top module: `dtrig_top`

## Requirements
- R1: A synchronous active-low reset clears every trigger enable, every pair chain bit and all three outputs. After reset, no trigger hits until it is written again.
- R2: When `cfg_we` is high and `cfg_idx` is 0 to 9, the whole setting of that trigger is written. A write changes the result only for events presented in later cycles. Writes with `cfg_idx` of 10 or more have no effect.
- R3: Trigger 2g and trigger 2g+1 form pair g. The pairs watch the following event kinds, for g = 0 to 4 in order: (fetch, fetch), (store, store), (load, load), (fetch, store), (fetch, load). A trigger compares only the address of its own kind, and only while that kind's valid bit is high.
- R4: The 2-bit match type selects an unsigned comparison of address against value: 0 is equal, 1 is greater than or equal, 2 is less than, and 3 never matches.
- R5: A trigger whose enable bit is 0 never matches. A trigger whose select bit is 1 asks for a data-value comparison, which is not supported, so it never matches either.
- R6: In an unchained pair, each trigger hits on its own match.
- R7: The chain bit written with the even trigger 2g chains pair g. A chained pair hits on both triggers only when both match in the same cycle and both have the same timing bit; otherwise neither hits. A disabled member therefore blocks the pair.
- R8: The (store, store) pair can never be chained. The chain bit written with trigger 2 is dropped.
- R9: The outputs update one clock after the event. `trap_hits` bit t is set for every trigger t that hit, and `trap_fire` is high exactly when any bit of `trap_hits` is set.
- R10: Timing bit 0 means trap on the current instruction and 1 means trap after it. `trap_after` is 0 whenever any hitting trigger has timing 0. It is 1 only when every hitting trigger has timing 1, and it is 0 when nothing fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Trigger setting write strobe |
| cfg_idx | input | 4 | Trigger number to write |
| cfg_enable | input | 1 | Enable bit to write |
| cfg_mtype | input | 2 | Match type to write |
| cfg_select | input | 1 | Select bit to write (1 = data compare, never matches) |
| cfg_after | input | 1 | Timing bit to write (1 = trap after instruction) |
| cfg_chain | input | 1 | Pair chain bit, taken from writes to even triggers |
| cfg_value | input | VAL_W | Compare value to write |
| fetch_vld | input | 1 | Fetch event valid |
| fetch_pc | input | VAL_W | Fetch PC |
| load_vld | input | 1 | Load event valid |
| load_addr | input | VAL_W | Load address |
| store_vld | input | 1 | Store event valid |
| store_addr | input | VAL_W | Store address |
| trap_fire | output | 1 | A trap is requested |
| trap_after | output | 1 | Requested trap is after the instruction |
| trap_hits | output | 10 | Triggers that hit |

## Verification
Each event is evaluated against the trigger settings held at that cycle. Its fire, timing and hit vector then appear after the next rising edge. The bench drives every stimulus just after a falling edge and reads the outputs at the following falling edge, so each check covers exactly one event. A setting write takes effect one cycle after it is presented. The bench therefore presents an event in the same cycle as a write and expects the old result, then repeats the event one cycle later and expects the new result. A reset is checked at the falling edge after the reset edge, and again with events that matched before the reset.

// File: rtl/dtrig_pkg.sv
// Package: shared types and the fixed pair layout of the debug trigger combiner.
// Assumes exactly five pairs of two triggers; the event kinds per pair are fixed.
package dtrig_pkg;

    localparam int NUM_GROUPS = 5;
    localparam int NUM_TRIG   = 2 * NUM_GROUPS;
    localparam int TRIG_IDX_W = $clog2(NUM_TRIG);

    // Comparison kinds held in the 2-bit match type field
    localparam logic [1:0] MT_EQ = 2'd0;
    localparam logic [1:0] MT_GE = 2'd1;
    localparam logic [1:0] MT_LT = 2'd2;

    typedef enum logic [1:0] {
        EV_FETCH = 2'd0,
        EV_STORE = 2'd1,
        EV_LOAD  = 2'd2
    } ev_kind_e;

    // Per-trigger control bits (the pair chain bit is kept per pair)
    typedef struct packed {
        logic       enable;
        logic [1:0] mtype;
        logic       sel_data;
        logic       after;
    } trig_ctl_t;

    // Event kind watched by trigger number idx
    function automatic ev_kind_e kind_of(input int idx);
        case (idx)
            0, 1, 6, 8: kind_of = EV_FETCH;
            2, 3, 7:    kind_of = EV_STORE;
            default:    kind_of = EV_LOAD;
        endcase
    endfunction

    // The store/store pair may not be chained
    function automatic logic chain_allowed(input int grp);
        chain_allowed = (grp != 1);
    endfunction

endpackage

// File: rtl/dtrig_cfg_bank.sv
// Module: register bank holding the settings of all triggers and the pair chain bits.
// Assumes one whole-trigger write per cycle; out-of-range indices write nothing.
// Reset clears enables and chain bits only; other fields keep their contents.
module dtrig_cfg_bank
    import dtrig_pkg::*;
#(
    parameter int VAL_W = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [TRIG_IDX_W-1:0]            wr_idx,
    input  trig_ctl_t                        wr_ctl,
    input  logic                             wr_chain,
    input  logic [VAL_W-1:0]                 wr_val,
    output trig_ctl_t [NUM_TRIG-1:0]         ctl_q,
    output logic [NUM_TRIG-1:0][VAL_W-1:0]   val_q,
    output logic [NUM_GROUPS-1:0]            chain_q
);

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
        trig_ctl_t         ctl_r;
        logic [VAL_W-1:0]  val_r;
        logic              sel;

        assign sel = wr_en && (wr_idx == TRIG_IDX_W'(t));

        // Store one trigger's setting; reset disables it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_r.enable <= 1'b0;
            end else if (sel) begin
                ctl_r <= wr_ctl;
                val_r <= wr_val;
            end
        end

        assign ctl_q[t] = ctl_r;
        assign val_q[t] = val_r;
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chain
        if (chain_allowed(g)) begin : g_reg
            logic chain_r;

            // Chain bit of a pair, taken from writes to its even trigger
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_r <= 1'b0;
                end else if (wr_en && (wr_idx == TRIG_IDX_W'(2 * g))) begin
                    chain_r <= wr_chain;
                end
            end

            assign chain_q[g] = chain_r;
        end else begin : g_tied
            assign chain_q[g] = 1'b0;
        end
    end

endmodule

// File: rtl/dtrig_match_unit.sv
// Module: compares one event address with one trigger's value.
// Assumes unsigned addresses; the select bit (data compare) is unsupported and never matches.
module dtrig_match_unit
    import dtrig_pkg::*;
#(
    parameter int VAL_W = 64
) (
    input  logic             ev_vld,
    input  logic [VAL_W-1:0] ev_addr,
    input  trig_ctl_t        ctl,
    input  logic [VAL_W-1:0] cmp_val,
    output logic             match
);

    logic rel;

    // Evaluate the selected relation and qualify it
    always_comb begin
        case (ctl.mtype)
            MT_EQ:   rel = (ev_addr == cmp_val);
            MT_GE:   rel = (ev_addr >= cmp_val);
            MT_LT:   rel = (ev_addr <  cmp_val);
            default: rel = 1'b0;
        endcase
        match = ev_vld && ctl.enable && !ctl.sel_data && rel;
    end

endmodule

// File: rtl/dtrig_pair_combine.sv
// Module: merges the two match results of one trigger pair.
// Assumes the chain bit has already been suppressed for pairs that may not chain.
module dtrig_pair_combine (
    input  logic       m_lo,
    input  logic       m_hi,
    input  logic       after_lo,
    input  logic       after_hi,
    input  logic       chained,
    output logic [1:0] hit
);

    logic both;

    // Chained pairs need both matches with agreeing timing
    always_comb begin
        both = m_lo && m_hi && (after_lo == after_hi);
        if (chained) begin
            hit = {both, both};
        end else begin
            hit = {m_hi, m_lo};
        end
    end

endmodule

// File: rtl/dtrig_top.sv
// Module: debug trigger hit combiner top. Routes each event kind to its triggers,
// combines pairs, prioritises timing and registers the trap request.
// Assumes at most one fetch, one load and one store event per cycle.
module dtrig_top
    import dtrig_pkg::*;
#(
    parameter int VAL_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [TRIG_IDX_W-1:0] cfg_idx,
    input  logic                  cfg_enable,
    input  logic [1:0]            cfg_mtype,
    input  logic                  cfg_select,
    input  logic                  cfg_after,
    input  logic                  cfg_chain,
    input  logic [VAL_W-1:0]      cfg_value,
    input  logic                  fetch_vld,
    input  logic [VAL_W-1:0]      fetch_pc,
    input  logic                  load_vld,
    input  logic [VAL_W-1:0]      load_addr,
    input  logic                  store_vld,
    input  logic [VAL_W-1:0]      store_addr,
    output logic                  trap_fire,
    output logic                  trap_after,
    output logic [NUM_TRIG-1:0]   trap_hits
);

    trig_ctl_t                       wr_ctl;
    trig_ctl_t [NUM_TRIG-1:0]        ctl;
    logic [NUM_TRIG-1:0][VAL_W-1:0]  cmp;
    logic [NUM_GROUPS-1:0]           chained;
    logic [NUM_TRIG-1:0]             raw;
    logic [NUM_TRIG-1:0]             after_vec;
    logic [NUM_TRIG-1:0]             hit_d;
    logic                            fire_d;
    logic                            now_d;
    logic                            after_d;

    assign wr_ctl = '{enable: cfg_enable, mtype: cfg_mtype,
                      sel_data: cfg_select, after: cfg_after};

    dtrig_cfg_bank #(.VAL_W(VAL_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_ctl   (wr_ctl),
        .wr_chain (cfg_chain),
        .wr_val   (cfg_value),
        .ctl_q    (ctl),
        .val_q    (cmp),
        .chain_q  (chained)
    );

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_match
        localparam ev_kind_e KIND = kind_of(t);
        logic             ev_v;
        logic [VAL_W-1:0] ev_a;

        if (KIND == EV_FETCH) begin : g_fetch
            assign ev_v = fetch_vld;
            assign ev_a = fetch_pc;
        end else if (KIND == EV_STORE) begin : g_store
            assign ev_v = store_vld;
            assign ev_a = store_addr;
        end else begin : g_load
            assign ev_v = load_vld;
            assign ev_a = load_addr;
        end

        dtrig_match_unit #(.VAL_W(VAL_W)) u_cmp (
            .ev_vld  (ev_v),
            .ev_addr (ev_a),
            .ctl     (ctl[t]),
            .cmp_val (cmp[t]),
            .match   (raw[t])
        );

        assign after_vec[t] = ctl[t].after;
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_pair
        dtrig_pair_combine u_pair (
            .m_lo     (raw[2*g]),
            .m_hi     (raw[2*g+1]),
            .after_lo (after_vec[2*g]),
            .after_hi (after_vec[2*g+1]),
            .chained  (chained[g]),
            .hit      (hit_d[2*g+1:2*g])
        );
    end

    // Current-instruction requests take priority over after-instruction ones
    always_comb begin
        fire_d  = |hit_d;
        now_d   = |(hit_d & ~after_vec);
        after_d = fire_d && !now_d;
    end

    // Register the trap request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_fire  <= 1'b0;
            trap_after <= 1'b0;
            trap_hits  <= '0;
        end else begin
            trap_fire  <= fire_d;
            trap_after <= after_d;
            trap_hits  <= hit_d;
        end
    end

endmodule

// File: rtl/dtrig_checker.sv
// Module: property checker for dtrig_top, attached with bind.
// Keeps its own copy of the pair chain bits, learned from the write port.
module dtrig_checker
    import dtrig_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_we,
    input logic [TRIG_IDX_W-1:0] cfg_idx,
    input logic                  cfg_chain,
    input logic                  fetch_vld,
    input logic                  load_vld,
    input logic                  store_vld,
    input logic                  trap_fire,
    input logic                  trap_after,
    input logic [NUM_TRIG-1:0]   trap_hits
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!trap_fire && trap_hits == '0)); // R1

    AST_NO_EVENT_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_vld && !load_vld && !store_vld) |=> !trap_fire); // R3

    AST_FETCH_ONLY_KINDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && !load_vld && !store_vld) |=>
        (trap_hits[5:2] == 4'b0 && !trap_hits[7] && !trap_hits[9])); // R3

    AST_STORE_ONLY_KINDS: assert property (@(posedge clk) disable iff (!rst_n)
        (store_vld && !fetch_vld && !load_vld) |=>
        (trap_hits[1:0] == 2'b0 && trap_hits[6:4] == 3'b0 && trap_hits[9:8] == 2'b0)); // R3

    AST_FIRE_IS_ANY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fire == (trap_hits != '0)); // R9

    AST_AFTER_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_fire |-> !trap_after); // R10

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_shadow
        if (g != 1) begin : g_chk
            logic sh_chain;

            // Track the chain bit this pair should hold
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_chain <= 1'b0;
                end else if (cfg_we && cfg_idx == TRIG_IDX_W'(2 * g)) begin
                    sh_chain <= cfg_chain;
                end
            end

            AST_CHAINED_PAIR_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
                sh_chain |=> (trap_hits[2*g] == trap_hits[2*g+1])); // R7
        end
    end

endmodule

bind dtrig_top dtrig_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_chain  (cfg_chain),
    .fetch_vld  (fetch_vld),
    .load_vld   (load_vld),
    .store_vld  (store_vld),
    .trap_fire  (trap_fire),
    .trap_after (trap_after),
    .trap_hits  (trap_hits)
);

// File: tb/sim_dtrig_top.sv
`timescale 1ns/1ps
module sim_dtrig_top;

    localparam int VW = 64;
    localparam int NV = 16;

    typedef struct packed {
        logic        fv;
        logic [15:0] fpc;
        logic        lv;
        logic [15:0] la;
        logic        sv;
        logic [15:0] sa;
        logic        fire;
        logic        aft;
        logic [9:0]  hits;
        logic [7:0]  req;
    } vec_t;

    // Expected results under the setup written in the main block
    localparam vec_t TBL [NV] = '{
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0,10'b0000000000, 8'd3},  // R3 idle
        '{1'b1,16'h0100, 1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b0,10'b0000000001, 8'd4},  // R4 eq
        '{1'b1,16'h0250, 1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b1,10'b0000000010, 8'd4},  // R4 ge
        '{1'b1,16'h0200, 1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b1,10'b0000000010, 8'd4},  // R4 ge edge
        '{1'b1,16'h01FF, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0,10'b0000000000, 8'd4},  // R4 below
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b1,16'h0300, 1'b1,1'b0,10'b0000000100, 8'd8},  // R8 store pair
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b1,16'h007F, 1'b1,1'b1,10'b0000001000, 8'd6},  // R6 lt
        '{1'b0,16'h0000, 1'b0,16'h0000, 1'b1,16'h0080, 1'b0,1'b0,10'b0000000000, 8'd4},  // R4 lt edge
        '{1'b0,16'h0000, 1'b1,16'h0400, 1'b0,16'h0000, 1'b1,1'b0,10'b0000110000, 8'd7},  // R7 both
        '{1'b0,16'h0000, 1'b1,16'h0500, 1'b0,16'h0000, 1'b0,1'b0,10'b0000000000, 8'd7},  // R7 one
        '{1'b1,16'h0500, 1'b0,16'h0000, 1'b1,16'h0600, 1'b1,1'b1,10'b0000000010, 8'd7},  // R7 timing
        '{1'b1,16'h0010, 1'b1,16'h0040, 1'b0,16'h0000, 1'b0,1'b0,10'b0000000000, 8'd5},  // R5 blocker
        '{1'b1,16'h0100, 1'b0,16'h0000, 1'b1,16'h007F, 1'b1,1'b0,10'b0000001001, 8'd10}, // R10 prio
        '{1'b0,16'h0100, 1'b1,16'h0400, 1'b0,16'h0000, 1'b1,1'b0,10'b0000110000, 8'd3},  // R3 valid
        '{1'b0,16'h0100, 1'b0,16'h0000, 1'b1,16'h0100, 1'b0,1'b0,10'b0000000000, 8'd3},  // R3 kind
        '{1'b1,16'h0250, 1'b0,16'h0000, 1'b1,16'h007F, 1'b1,1'b1,10'b0000001010, 8'd9}   // R9 multi
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cfg_we;
    logic [3:0]     cfg_idx;
    logic           cfg_enable;
    logic [1:0]     cfg_mtype;
    logic           cfg_select;
    logic           cfg_after;
    logic           cfg_chain;
    logic [VW-1:0]  cfg_value;
    logic           fetch_vld;
    logic [VW-1:0]  fetch_pc;
    logic           load_vld;
    logic [VW-1:0]  load_addr;
    logic           store_vld;
    logic [VW-1:0]  store_addr;
    logic           trap_fire;
    logic           trap_after;
    logic [9:0]     trap_hits;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    dtrig_top #(.VAL_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_enable(cfg_enable),
        .cfg_mtype(cfg_mtype), .cfg_select(cfg_select), .cfg_after(cfg_after),
        .cfg_chain(cfg_chain), .cfg_value(cfg_value),
        .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
        .load_vld(load_vld), .load_addr(load_addr),
        .store_vld(store_vld), .store_addr(store_addr),
        .trap_fire(trap_fire), .trap_after(trap_after), .trap_hits(trap_hits)
    );

    task automatic check(input string req, input logic ef, input logic ea, input logic [9:0] eh);
        checks++;
        if (trap_fire !== ef || trap_after !== ea || trap_hits !== eh) begin
            errors++;
            $display("FAIL %s: fire/after/hits actual %b/%b/%b expected %b/%b/%b",
                     req, trap_fire, trap_after, trap_hits, ef, ea, eh);
        end
    endtask

    // Present a write for one cycle (stays until the next drive)
    task automatic cfg_set(input int idx, input logic en, input logic [1:0] mt, input logic sel,
                           input logic aft, input logic ch, input logic [15:0] val);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_enable = en; cfg_mtype = mt;
        cfg_select = sel; cfg_after = aft; cfg_chain = ch; cfg_value = VW'(val);
    endtask

    task automatic ev(input logic fv, input logic [15:0] f, input logic lv, input logic [15:0] l,
                      input logic sv, input logic [15:0] s);
        fetch_vld = fv; fetch_pc = VW'(f); load_vld = lv; load_addr = VW'(l);
        store_vld = sv; store_addr = VW'(s);
    endtask

    task automatic step;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_cfg(input int idx, input logic en, input logic [1:0] mt, input logic sel,
                             input logic aft, input logic ch, input logic [15:0] val);
        cfg_set(idx, en, mt, sel, aft, ch, val);
        step();
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_we = 1'b0; cfg_idx = '0; cfg_enable = 1'b0; cfg_mtype = '0;
        cfg_select = 1'b0; cfg_after = 1'b0; cfg_chain = 1'b0; cfg_value = '0;
        ev(0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: nothing enabled after reset
        check("R1 reset outputs", 1'b0, 1'b0, 10'b0);
        ev(1, 16'h0100, 1, 16'h0400, 1, 16'h0300);
        step();
        check("R1 disabled after reset", 1'b0, 1'b0, 10'b0);
        ev(0, 0, 0, 0, 0, 0);

        // Setup: idx, enable, mtype, select, after, chain, value
        write_cfg(0, 1, 2'd0, 0, 0, 0, 16'h0100);
        write_cfg(1, 1, 2'd1, 0, 1, 0, 16'h0200);
        write_cfg(2, 1, 2'd0, 0, 0, 1, 16'h0300); // R8 chain request dropped
        write_cfg(3, 1, 2'd2, 0, 1, 0, 16'h0080);
        write_cfg(4, 1, 2'd0, 0, 0, 1, 16'h0400);
        write_cfg(5, 1, 2'd1, 0, 0, 0, 16'h0400);
        write_cfg(6, 1, 2'd0, 0, 1, 1, 16'h0500);
        write_cfg(7, 1, 2'd0, 0, 0, 0, 16'h0600);
        write_cfg(8, 1, 2'd2, 0, 1, 1, 16'h0050);
        write_cfg(9, 0, 2'd0, 0, 1, 0, 16'h0040);

        for (int i = 0; i < NV; i++) begin
            ev(TBL[i].fv, TBL[i].fpc, TBL[i].lv, TBL[i].la, TBL[i].sv, TBL[i].sa);
            step();
            check($sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].fire, TBL[i].aft, TBL[i].hits);
        end

        // R2: a write does not affect an event in the same cycle
        cfg_set(0, 1, 2'd0, 0, 0, 0, 16'h0180);
        ev(1, 16'h0180, 0, 0, 0, 0);
        step();
        check("R2 same-cycle write", 1'b0, 1'b0, 10'b0);
        step();
        check("R2 next-cycle effect", 1'b1, 1'b0, 10'b0000000001);
        ev(1, 16'h0100, 0, 0, 0, 0);
        step();
        check("R2 old value gone", 1'b0, 1'b0, 10'b0);

        // R2: out-of-range indices write nothing
        for (int k = 10; k < 16; k++) write_cfg(k, 1, 2'd0, 0, 0, 1, 16'h01C0);
        ev(1, 16'h01C0, 0, 0, 0, 0);
        step();
        check("R2 index 10..15 ignored", 1'b0, 1'b0, 10'b0);
        ev(1, 16'h0180, 0, 0, 0, 0);
        step();
        check("R2 trigger 0 kept", 1'b1, 1'b0, 10'b0000000001);

        // R4: match type 3 never matches
        write_cfg(0, 1, 2'd3, 0, 0, 0, 16'h0180);
        ev(1, 16'h0180, 0, 0, 0, 0);
        step();
        check("R4 type 3 never", 1'b0, 1'b0, 10'b0);

        // R5: select bit set never matches
        write_cfg(0, 1, 2'd0, 1, 0, 0, 16'h0180);
        ev(1, 16'h0180, 0, 0, 0, 0);
        step();
        check("R5 select never", 1'b0, 1'b0, 10'b0);
        write_cfg(0, 1, 2'd0, 0, 0, 0, 16'h0180);
        step();
        check("R5 select cleared", 1'b1, 1'b0, 10'b0000000001);

        // R1: mid-run reset clears enables and chain bits
        ev(0, 0, 1, 16'h0400, 0, 0);
        rst_n = 1'b0;
        step();
        check("R1 outputs during reset", 1'b0, 1'b0, 10'b0);
        rst_n = 1'b1;
        step();
        check("R1 enables cleared", 1'b0, 1'b0, 10'b0);
        write_cfg(5, 1, 2'd1, 0, 0, 0, 16'h0400);
        ev(0, 0, 1, 16'h0500, 0, 0);
        step();
        check("R1 chain cleared", 1'b1, 1'b0, 10'b0000100000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule